// File: doc/BRIEF.md
# 1-Wire Bus Timing Engine

This block is the low-level timing engine of a 1-Wire bus master. It drives one open-drain line through an active-low drive enable and reads the line back through a synchroniser. All bus timing is counted in microsecond ticks that a parameterised divider derives from the system clock. Three operations are offered: a bus reset with presence detection and a shorted-line check, a single bit time slot, and a byte made of eight slots sent least-significant bit first. Reading is the same slot as writing: writing a 1 releases the line early and lets a device pull it low, so a byte read is a byte write of 0xFF.

Commands enter on a valid/ready channel carrying the operation, the write byte, a strong pull-up request and a recovery time in microseconds. A command transfers on a clock edge where `cmd_valid` and `cmd_ready` are both high; `cmd_ready` is high only when the engine is idle with no result waiting. Results leave on a second valid/ready channel. `rsp_valid` stays high, with all result fields held, until the consumer raises `rsp_ready`; while a result waits, no new command is taken, so back-pressure on the result channel stalls the command channel. When a strong pull-up is requested, it is switched on at the end of the last slot instead of the normal recovery release and stays on until the next command transfers.

Top module: `owm_master`

## Requirements
- R1: A reset operation (`cmd_op` = 0) drives the line low for 480 us and then releases it.
- R2: In a reset, the line is sampled 64 us after release; a low level there sets `rsp_presence` to 1, a high level sets it to 0.
- R3: In a reset, the line is sampled again 416 us after the presence sample; if it is still low, `rsp_short` is 1, otherwise 0.
- R4: Every slot drives the line low for 2 us at its start; a written 1 then releases it, while a written 0 keeps it low until 60 us after the slot start.
- R5: A slot samples the line 15 us after its start; the returned bit is 0 when the line is low there, otherwise it equals the written bit. A single-slot operation (`cmd_op` = 1) writes `cmd_data[0]` and returns the sampled bit in `rsp_data[0]` with bits 7..1 zero.
- R6: After the 60 us of a slot, the line stays released for `cmd_rec_us` microseconds (none when 0) before the next slot of the byte starts.
- R7: A byte operation (`cmd_op` = 2 or 3) sends `cmd_data` bit 0 first; each sampled bit enters bit 7 of a right-shifting register, so `rsp_data` bit i holds the bit sampled in slot i.
- R8: A byte written as 0xFF releases the line in every slot and returns the byte the devices send.
- R9: With `cmd_spu` set, `strong_pullup` turns on after the last slot of the operation (the eighth slot of a byte, or the single slot), skipping recovery, and turns off at the clock edge where the next command transfers; `strong_pullup` and `drive_low` are never high together.
- R10: `cmd_ready` is low from the transfer of a command until its result has been taken; while `rsp_valid` is high and `rsp_ready` low, the result fields stay unchanged.
- R11: After reset, and whenever the engine is idle, `drive_low` and `strong_pullup` are 0 (except a requested strong pull-up), `rsp_valid` is 0 after reset and `cmd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command will be taken |
| cmd_op | input | 2 | 0 reset, 1 single slot, 2 or 3 byte |
| cmd_data | input | 8 | Byte (or bit 0) to write |
| cmd_spu | input | 1 | Strong pull-up after the last slot |
| cmd_rec_us | input | 8 | Recovery time after each slot in us |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Result taken |
| rsp_data | output | 8 | Bit or byte read back |
| rsp_presence | output | 1 | A device answered the reset |
| rsp_short | output | 1 | Line still low at the end of the reset |
| line_in | input | 1 | Level of the bus line |
| drive_low | output | 1 | Pull the line low when 1 |
| strong_pullup | output | 1 | Strong pull-up enable |

## Verification
Resets are run against an empty bus, a bus with an answering device and a bus held low, which separates the presence sample from the shorted-line sample. Slots and bytes are run with written and device bytes chosen so that ones, zeros and mixed patterns meet in each slot, showing that the result is the AND of the written and device bits and that bit 0 goes first; the measured low widths tell a written 1 from a written 0. Slot spacing is measured with zero and non-zero recovery, and the strong pull-up is checked after a byte and after a single slot and again after the following command transfers, with the result channel stalled for several cycles each time.

// File: rtl/owm_pkg.sv
package owm_pkg;

  typedef enum logic [1:0] {
    OP_RESET    = 2'd0,
    OP_SLOT     = 2'd1,
    OP_BYTE     = 2'd2,
    OP_BYTE_ALT = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_RLOW,
    SQ_RPRES,
    SQ_RTAIL,
    SQ_SINIT,
    SQ_SMID,
    SQ_SREST,
    SQ_SREC
  } seq_e;

  typedef enum logic [1:0] {
    CT_IDLE,
    CT_RUN,
    CT_RSP
  } ctl_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/owm_tick.sv
module owm_tick #(
  parameter int DIV = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [W-1:0] cnt;

  assign tick = (cnt == W'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/owm_sync.sv
module owm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/owm_seq.sv
module owm_seq
  import owm_pkg::*;
#(
  parameter int T_RST_LOW  = 480,
  parameter int T_PRES     = 64,
  parameter int T_RST_TAIL = 416,
  parameter int T_INIT     = 2,
  parameter int T_SAMPLE   = 15,
  parameter int T_SLOT     = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       start,
  input  logic       is_reset,
  input  logic       wbit,
  input  logic       skip_rec,
  input  logic [7:0] rec_us,
  input  logic       line_s,
  output logic       tick_clr,
  output logic       drive_low,
  output logic       done,
  output logic       rbit,
  output logic       presence,
  output logic       shorted
);
  localparam int LONGEST = max3(T_RST_LOW, T_RST_TAIL, 256);
  localparam int CW      = $clog2(LONGEST + 1);

  seq_e          st;
  logic [CW-1:0] cnt;
  logic [CW-1:0] span;
  logic          wbit_q;
  logic          skip_q;
  logic [7:0]    rec_q;
  logic          last_tick;

  always_comb begin
    case (st)
      SQ_RLOW:  span = CW'(T_RST_LOW);
      SQ_RPRES: span = CW'(T_PRES);
      SQ_RTAIL: span = CW'(T_RST_TAIL);
      SQ_SINIT: span = CW'(T_INIT);
      SQ_SMID:  span = CW'(T_SAMPLE - T_INIT);
      SQ_SREST: span = CW'(T_SLOT - T_SAMPLE);
      SQ_SREC:  span = CW'(rec_q);
      default:  span = CW'(1);
    endcase
  end

  assign last_tick = tick && (cnt == span - 1'b1);
  assign tick_clr  = start && (st == SQ_IDLE);
  assign drive_low = (st == SQ_RLOW) || (st == SQ_SINIT) ||
                     (((st == SQ_SMID) || (st == SQ_SREST)) && !wbit_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= SQ_IDLE;
      cnt      <= '0;
      wbit_q   <= 1'b1;
      skip_q   <= 1'b0;
      rec_q    <= '0;
      done     <= 1'b0;
      rbit     <= 1'b0;
      presence <= 1'b0;
      shorted  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == SQ_IDLE) begin
        if (start) begin
          st     <= is_reset ? SQ_RLOW : SQ_SINIT;
          cnt    <= '0;
          wbit_q <= wbit;
          skip_q <= skip_rec;
          rec_q  <= rec_us;
        end
      end else if (tick) begin
        if (last_tick) begin
          cnt <= '0;
          case (st)
            SQ_RLOW:  st <= SQ_RPRES;
            SQ_RPRES: begin
              presence <= !line_s;
              st       <= SQ_RTAIL;
            end
            SQ_RTAIL: begin
              shorted <= !line_s;
              st      <= SQ_IDLE;
              done    <= 1'b1;
            end
            SQ_SINIT: st <= SQ_SMID;
            SQ_SMID: begin
              rbit <= wbit_q && line_s;
              st   <= SQ_SREST;
            end
            SQ_SREST: begin
              if (skip_q || (rec_q == 8'd0)) begin
                st   <= SQ_IDLE;
                done <= 1'b1;
              end else begin
                st <= SQ_SREC;
              end
            end
            SQ_SREC: begin
              st   <= SQ_IDLE;
              done <= 1'b1;
            end
            default: st <= SQ_IDLE;
          endcase
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/owm_master.sv
module owm_master
  import owm_pkg::*;
#(
  parameter int CLK_PER_US  = 125,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int T_RST_LOW   = 480,
  parameter int T_PRES      = 64,
  parameter int T_RST_TAIL  = 416,
  parameter int T_INIT      = 2,
  parameter int T_SAMPLE    = 15,
  parameter int T_SLOT      = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              cmd_spu,
  input  logic [7:0]        cmd_rec_us,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_presence,
  output logic              rsp_short,
  input  logic              line_in,
  output logic              drive_low,
  output logic              strong_pullup
);
  localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  ctl_e              cst;
  op_e               op_q;
  logic [DATA_W-1:0] shreg;
  logic [IW-1:0]     bit_idx;
  logic              spu_q;
  logic [7:0]        rec_q;
  logic              start_q;
  logic              last_slot;

  logic tick, tick_clr, line_s;
  logic seq_done, seq_rbit, seq_pres, seq_short;

  owm_tick #(.DIV(CLK_PER_US)) i_tick (
    .clk(clk), .rst_n(rst_n), .clr(tick_clr), .tick(tick)
  );

  owm_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .d(line_in), .q(line_s)
  );

  assign last_slot = (op_q == OP_SLOT) || (bit_idx == IW'(DATA_W - 1));

  owm_seq #(
    .T_RST_LOW(T_RST_LOW), .T_PRES(T_PRES), .T_RST_TAIL(T_RST_TAIL),
    .T_INIT(T_INIT), .T_SAMPLE(T_SAMPLE), .T_SLOT(T_SLOT)
  ) i_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .start    (start_q),
    .is_reset (op_q == OP_RESET),
    .wbit     (shreg[0]),
    .skip_rec (spu_q && last_slot),
    .rec_us   (rec_q),
    .line_s   (line_s),
    .tick_clr (tick_clr),
    .drive_low(drive_low),
    .done     (seq_done),
    .rbit     (seq_rbit),
    .presence (seq_pres),
    .shorted  (seq_short)
  );

  assign cmd_ready = (cst == CT_IDLE);
  assign rsp_valid = (cst == CT_RSP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cst           <= CT_IDLE;
      op_q          <= OP_RESET;
      shreg         <= '0;
      bit_idx       <= '0;
      spu_q         <= 1'b0;
      rec_q         <= '0;
      start_q       <= 1'b0;
      strong_pullup <= 1'b0;
      rsp_data      <= '0;
      rsp_presence  <= 1'b0;
      rsp_short     <= 1'b0;
    end else begin
      start_q <= 1'b0;
      case (cst)
        CT_IDLE: begin
          if (cmd_valid) begin
            op_q          <= op_e'(cmd_op);
            shreg         <= cmd_data;
            bit_idx       <= '0;
            spu_q         <= cmd_spu;
            rec_q         <= cmd_rec_us;
            start_q       <= 1'b1;
            strong_pullup <= 1'b0;
            cst           <= CT_RUN;
          end
        end
        CT_RUN: begin
          if (seq_done) begin
            if (op_q == OP_RESET) begin
              rsp_data     <= '0;
              rsp_presence <= seq_pres;
              rsp_short    <= seq_short;
              cst          <= CT_RSP;
            end else if (op_q == OP_SLOT) begin
              rsp_data      <= {{(DATA_W-1){1'b0}}, seq_rbit};
              rsp_presence  <= 1'b0;
              rsp_short     <= 1'b0;
              strong_pullup <= spu_q;
              cst           <= CT_RSP;
            end else begin
              shreg <= {seq_rbit, shreg[DATA_W-1:1]};
              if (last_slot) begin
                rsp_data      <= {seq_rbit, shreg[DATA_W-1:1]};
                rsp_presence  <= 1'b0;
                rsp_short     <= 1'b0;
                strong_pullup <= spu_q;
                cst           <= CT_RSP;
              end else begin
                bit_idx <= bit_idx + 1'b1;
                start_q <= 1'b1;
              end
            end
          end
        end
        CT_RSP: begin
          if (rsp_ready) cst <= CT_IDLE;
        end
        default: cst <= CT_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/owm_master_chk.sv
module owm_master_chk #(
  parameter int CLK_PER_US = 125,
  parameter int T_RST_LOW  = 480
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [7:0] rsp_data,
  input logic       rsp_presence,
  input logic       rsp_short,
  input logic       drive_low,
  input logic       strong_pullup
);
  localparam int LOW_MAX = T_RST_LOW * CLK_PER_US;

  int unsigned low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         low_run <= 0;
    else if (drive_low) low_run <= low_run + 1;
    else                low_run <= 0;
  end

  AST_LOW_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= LOW_MAX); // R1

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(drive_low && strong_pullup)); // R9

  AST_SPU_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !strong_pullup); // R9

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) &&
                                   $stable(rsp_presence) && $stable(rsp_short))); // R10

  AST_RSP_BLOCKS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cmd_ready); // R10

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !drive_low); // R11
endmodule

bind owm_master owm_master_chk #(
  .CLK_PER_US(CLK_PER_US),
  .T_RST_LOW (T_RST_LOW)
) i_owm_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_valid    (cmd_valid),
  .cmd_ready    (cmd_ready),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_data     (rsp_data),
  .rsp_presence (rsp_presence),
  .rsp_short    (rsp_short),
  .drive_low    (drive_low),
  .strong_pullup(strong_pullup)
);

// File: tb/test_owm_master.sv
module test_owm_master;
  localparam int N = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [1:0] cmd_op = 2'd0;
  logic [7:0] cmd_data = 8'h00;
  logic       cmd_spu = 1'b0;
  logic [7:0] cmd_rec_us = 8'd0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b0;
  logic [7:0] rsp_data;
  logic       rsp_presence;
  logic       rsp_short;
  logic       line_in;
  logic       drive_low;
  logic       strong_pullup;
  logic       dev_pull = 1'b0;

  always #4 clk = ~clk;

  assign line_in = !(drive_low || dev_pull);

  owm_master #(.CLK_PER_US(N)) i_owm_master (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .cmd_spu(cmd_spu), .cmd_rec_us(cmd_rec_us),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_presence(rsp_presence), .rsp_short(rsp_short),
    .line_in(line_in), .drive_low(drive_low), .strong_pullup(strong_pullup)
  );

  int n_tests = 0;
  int n_fail  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // device model: 0 none, 1 presence, 2 shorted, 3 bit data
  int       dev_mode = 0;
  logic [7:0] dev_byte = 8'hFF;
  int       dev_idx = 0;

  initial begin
    forever begin
      @(posedge drive_low);
      if (dev_mode == 1) begin
        @(negedge drive_low);
        repeat (15 * N) @(negedge clk);
        dev_pull = 1'b1;
        repeat (120 * N) @(negedge clk);
        dev_pull = 1'b0;
      end else if (dev_mode == 2) begin
        @(negedge drive_low);
        repeat (5 * N) @(negedge clk);
        dev_pull = 1'b1;
      end else if (dev_mode == 3) begin
        logic b;
        b = dev_byte[dev_idx % 8];
        dev_idx++;
        if (!b) begin
          @(negedge clk);
          dev_pull = 1'b1;
          repeat (30 * N) @(negedge clk);
          dev_pull = 1'b0;
        end
      end
    end
  end

  // line monitor: low widths and start cycles of drive_low
  int  widths[$];
  int  starts[$];
  int  cyc = 0;
  int  wcnt = 0;
  logic prev_dl = 1'b0;

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (drive_low && !prev_dl) begin
        starts.push_back(cyc);
        wcnt = 0;
      end
      if (drive_low) wcnt++;
      if (!drive_low && prev_dl) widths.push_back(wcnt);
      prev_dl = drive_low;
    end
  end

  // scoreboard
  typedef struct {
    logic [7:0] d;
    logic       p;
    logic       s;
    string      tag;
  } exp_t;
  exp_t expq[$];

  initial begin
    int stall;
    stall = 0;
    forever begin
      @(negedge clk);
      if (rsp_valid) begin
        if (stall == 0)
          check(!cmd_ready, "R10", "cmd_ready while result waits", cmd_ready, 0);
        if (stall < 3) begin
          rsp_ready = 1'b0;
          stall++;
        end else begin
          exp_t e;
          e = expq.pop_front();
          check(rsp_data == e.d, e.tag, "rsp_data", rsp_data, e.d);
          check(rsp_presence == e.p && rsp_short == e.s, e.tag,
                "presence/short", {rsp_presence, rsp_short}, {e.p, e.s});
          rsp_ready = 1'b1;
          stall = 0;
        end
      end else begin
        rsp_ready = 1'b0;
      end
    end
  end

  task automatic run(input logic [1:0] op, input logic [7:0] data,
                     input logic spu, input logic [7:0] rec,
                     input logic [7:0] ed, input logic ep, input logic es,
                     input string tag);
    exp_t e;
    e.d = ed; e.p = ep; e.s = es; e.tag = tag;
    widths.delete();
    starts.delete();
    dev_idx = 0;
    expq.push_back(e);
    @(negedge clk);
    cmd_op = op; cmd_data = data; cmd_spu = spu; cmd_rec_us = rec;
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    check(strong_pullup == 1'b0, "R9", "pull-up off after transfer", strong_pullup, 0);
    while (expq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic bit near(input int a, input int b, input int tol);
    return (a >= b - tol) && (a <= b + tol);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(drive_low == 0 && strong_pullup == 0, "R11", "line idle after reset",
          {drive_low, strong_pullup}, 0);
    check(rsp_valid == 0 && cmd_ready == 1, "R11", "handshake after reset",
          {rsp_valid, cmd_ready}, 1);

    // empty bus
    dev_mode = 0;
    run(2'd0, 8'h00, 1'b0, 8'd0, 8'h00, 1'b0, 1'b0, "R2");
    check(widths.size() == 1 && near(widths[0], 480 * N, 1), "R1", "reset low width",
          widths.size() > 0 ? widths[0] : -1, 480 * N);

    // answering device
    dev_mode = 1;
    run(2'd0, 8'h00, 1'b0, 8'd0, 8'h00, 1'b1, 1'b0, "R2");

    // shorted bus
    dev_mode = 2;
    run(2'd0, 8'h00, 1'b0, 8'd0, 8'h00, 1'b1, 1'b1, "R3");
    dev_pull = 1'b0;

    // single slots
    dev_mode = 3;
    dev_byte = 8'hFF;
    run(2'd1, 8'h01, 1'b0, 8'd3, 8'h01, 1'b0, 1'b0, "R5");
    check(widths.size() == 1 && near(widths[0], 2 * N, 1), "R4", "write-1 low width",
          widths.size() > 0 ? widths[0] : -1, 2 * N);
    dev_byte = 8'h00;
    run(2'd1, 8'h01, 1'b0, 8'd3, 8'h00, 1'b0, 1'b0, "R5");
    dev_byte = 8'hFF;
    run(2'd1, 8'hFE, 1'b0, 8'd3, 8'h00, 1'b0, 1'b0, "R5");
    check(widths.size() == 1 && near(widths[0], 60 * N, 1), "R4", "write-0 low width",
          widths.size() > 0 ? widths[0] : -1, 60 * N);

    // byte write, LSB first, recovery 5 us
    dev_byte = 8'hFF;
    run(2'd2, 8'hA5, 1'b0, 8'd5, 8'hA5, 1'b0, 1'b0, "R7");
    check(widths.size() == 8 && near(widths[0], 2 * N, 1) && near(widths[1], 60 * N, 1),
          "R7", "bit 0 sent first", widths.size() > 1 ? widths[1] : -1, 60 * N);
    check(starts.size() == 8 && near(starts[1] - starts[0], 65 * N, 3), "R6",
          "slot spacing with recovery", starts.size() > 1 ? starts[1] - starts[0] : -1, 65 * N);

    // byte with mixed device data
    dev_byte = 8'h0F;
    run(2'd3, 8'h5A, 1'b0, 8'd0, 8'h0A, 1'b0, 1'b0, "R7");
    check(starts.size() == 8 && near(starts[7] - starts[6], 60 * N, 3), "R6",
          "slot spacing no recovery", starts.size() > 7 ? starts[7] - starts[6] : -1, 60 * N);

    // byte read
    dev_byte = 8'h3C;
    run(2'd2, 8'hFF, 1'b0, 8'd1, 8'h3C, 1'b0, 1'b0, "R8");
    check(widths.size() == 8 && near(widths[2], 2 * N, 1), "R8", "read releases line",
          widths.size() > 2 ? widths[2] : -1, 2 * N);

    // strong pull-up after a byte
    dev_byte = 8'h96;
    run(2'd2, 8'hFF, 1'b1, 8'd4, 8'h96, 1'b0, 1'b0, "R9");
    check(strong_pullup == 1 && drive_low == 0, "R9", "pull-up on after byte",
          {strong_pullup, drive_low}, 2);

    // next command drops it (checked in run), then a single slot with pull-up
    dev_byte = 8'h00;
    run(2'd1, 8'h01, 1'b1, 8'd4, 8'h00, 1'b0, 1'b0, "R9");
    check(strong_pullup == 1, "R9", "pull-up on after slot", strong_pullup, 1);

    dev_mode = 1;
    run(2'd0, 8'h00, 1'b0, 8'd0, 8'h00, 1'b1, 1'b0, "R2");
    check(strong_pullup == 0 && cmd_ready == 1, "R11", "idle after reset op",
          {strong_pullup, cmd_ready}, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", 200000, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule